// File: doc/BRIEF.md
# Fare-Gate Turnstile Controller

This block is a clocked Moore controller for a fare gate. It watches three level inputs that are already synchronised to its clock: a card being presented, a passenger moving through the gate, and an attendant clearing the alarm. From these it tracks whether the gate is locked, open for one passage, or in alarm after someone passed without paying. One output holds the gate locked. The present state is also driven out so that surrounding logic can tell an open gate from one in alarm.

The next state comes from two fixed product-of-inputs equations, one for each state bit. At one point these equations would produce the spare two-bit code: alarm with only a card present. There the controller keeps its present state. If the state register ever holds the spare code, it returns to locked on the next clock. Both the lock output and the state depend only on the registered state, so a change on an input shows up one clock later.

Top module: `turnstile_gate`

## Requirements
- R1: While `rst` is high at a rising clock edge, the state becomes locked (`state_o` = 2'b00) and `lock_o` is 1 after that edge.
- R2: From locked, `card_i`=1 with `pass_i`=0 and `alarm_clr_i`=0 moves the state to open (`state_o` = 2'b01).
- R3: From locked, `pass_i`=1 with `card_i`=0 and `alarm_clr_i`=0 moves the state to alarm (`state_o` = 2'b10).
- R4: From locked, every other input combination keeps the state locked. This covers no input, card and passage together, and any combination with `alarm_clr_i`=1.
- R5: From open, the state returns to locked exactly when `pass_i`=1 and `card_i`=0, whatever `alarm_clr_i` is. Otherwise it stays open.
- R6: From alarm, the state stays alarm while `alarm_clr_i`=0, including when only a card is present. It moves to locked on a clock edge where `alarm_clr_i`=1.
- R7: `lock_o` is 1 exactly when `state_o` is 2'b00. It is 0 in open, in alarm and in the spare code 2'b11.
- R8: The spare code 2'b11 is never entered from a legal state. If the register holds it, the next clock moves the state to locked.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high, forces locked |
| card_i | input | 1 | A valid card is presented (level) |
| pass_i | input | 1 | A passenger is moving through the gate (level) |
| alarm_clr_i | input | 1 | Attendant clears the alarm (level) |
| state_o | output | 2 | Present state: 00 locked, 01 open, 10 alarm |
| lock_o | output | 1 | 1 holds the gate locked |

## Verification
On every clock, the assertions check each transition out of the locked, open and alarm states. They also check that the lock output matches the state, that the spare code is never produced, and that reset lands in locked. The bench scenarios show whole sequences: a card then a passage, a sneak-through held until an attendant clears it, and a reset taken from the open and alarm states. Each step is compared against values worked out from the requirements. The recovery from the spare code cannot be reached from the ports, so only its assertion covers it.

// File: rtl/turnstile_pkg.sv
package turnstile_pkg;

  localparam int unsigned GATE_STATE_W = 2;

  typedef enum logic [GATE_STATE_W-1:0] {
    GATE_LOCKED = 2'b00,
    GATE_OPEN   = 2'b01,
    GATE_ALARM  = 2'b10,
    GATE_SPARE  = 2'b11
  } gate_state_e;

endpackage

// File: rtl/turnstile_next.sv
module turnstile_next
  import turnstile_pkg::*;
(
  input  logic        card,
  input  logic        pass,
  input  logic        alarm_clr,
  input  gate_state_e cur,
  output gate_state_e nxt
);

  logic hi_eq;
  logic lo_eq;

  // Fixed equations for the high and low state bits
  always_comb begin
    hi_eq = (cur[1] & ~alarm_clr) | (~cur[0] & ~alarm_clr & pass & ~card);
    lo_eq = (cur[0] & ~pass) | (cur[0] & card) | (~alarm_clr & ~pass & card);
  end

  always_comb begin
    if (cur == GATE_SPARE) begin
      nxt = GATE_LOCKED;                       // R8 recovery
    end else if ({hi_eq, lo_eq} == 2'b11) begin
      nxt = cur;                               // R6: alarm with only a card stays alarm
    end else begin
      nxt = gate_state_e'({hi_eq, lo_eq});
    end
  end

  always_comb begin
    if (!$isunknown({cur, card, pass, alarm_clr})) begin
      a_r8_no_spare_target: assert (nxt != GATE_SPARE)
        else $error("next state is the spare code");
    end
  end

endmodule

// File: rtl/turnstile_state_reg.sv
module turnstile_state_reg
  import turnstile_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  gate_state_e nxt,
  output gate_state_e cur
);

  always_ff @(posedge clk) begin
    if (rst) cur <= GATE_LOCKED;
    else     cur <= nxt;
  end

  a_r1_reset_locks: assert property (@(posedge clk) rst |=> cur == GATE_LOCKED)
    else $error("reset did not reach locked");

endmodule

// File: rtl/turnstile_out_dec.sv
module turnstile_out_dec
  import turnstile_pkg::*;
(
  input  gate_state_e cur,
  output logic        lock
);

  always_comb lock = ~(cur[1] | cur[0]);

endmodule

// File: rtl/turnstile_gate.sv
module turnstile_gate
  import turnstile_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       card_i,
  input  logic       pass_i,
  input  logic       alarm_clr_i,
  output logic [1:0] state_o,
  output logic       lock_o
);

  gate_state_e cur;
  gate_state_e nxt;

  turnstile_next u_next (
    .card      (card_i),
    .pass      (pass_i),
    .alarm_clr (alarm_clr_i),
    .cur       (cur),
    .nxt       (nxt)
  );

  turnstile_state_reg u_reg (
    .clk (clk),
    .rst (rst),
    .nxt (nxt),
    .cur (cur)
  );

  turnstile_out_dec u_dec (
    .cur  (cur),
    .lock (lock_o)
  );

  assign state_o = cur;

  a_r2_card_opens: assert property (@(posedge clk) disable iff (rst)
    (state_o == 2'b00 && card_i && !pass_i && !alarm_clr_i) |=> state_o == 2'b01)
    else $error("card did not open gate");

  a_r3_sneak_alarms: assert property (@(posedge clk) disable iff (rst)
    (state_o == 2'b00 && pass_i && !card_i && !alarm_clr_i) |=> state_o == 2'b10)
    else $error("sneak did not raise alarm");

  a_r4_locked_holds: assert property (@(posedge clk) disable iff (rst)
    (state_o == 2'b00 && (alarm_clr_i || (card_i == pass_i))) |=> state_o == 2'b00)
    else $error("locked gate left without cause");

  a_r5_open_closes: assert property (@(posedge clk) disable iff (rst)
    (state_o == 2'b01 && pass_i && !card_i) |=> state_o == 2'b00)
    else $error("open gate did not close after passage");

  a_r5_open_holds: assert property (@(posedge clk) disable iff (rst)
    (state_o == 2'b01 && !(pass_i && !card_i)) |=> state_o == 2'b01)
    else $error("open gate closed early");

  a_r6_alarm_holds: assert property (@(posedge clk) disable iff (rst)
    (state_o == 2'b10 && !alarm_clr_i) |=> state_o == 2'b10)
    else $error("alarm left without clear");

  a_r6_alarm_clears: assert property (@(posedge clk) disable iff (rst)
    (state_o == 2'b10 && alarm_clr_i) |=> state_o == 2'b00)
    else $error("alarm clear ignored");

  a_r7_lock_matches: assert property (@(posedge clk) disable iff (rst)
    lock_o == (state_o == 2'b00))
    else $error("lock output disagrees with state");

  a_r8_spare_recovers: assert property (@(posedge clk) disable iff (rst)
    (state_o == 2'b11) |=> state_o == 2'b00)
    else $error("spare code did not recover");

endmodule

// File: tb/test_turnstile_gate.sv
module test_turnstile_gate;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       card_i = 1'b0;
  logic       pass_i = 1'b0;
  logic       alarm_clr_i = 1'b0;
  logic [1:0] state_o;
  logic       lock_o;

  int applied = 0;
  int bad = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;  // 250 MHz

  turnstile_gate i_turnstile_gate (
    .clk         (clk),
    .rst         (rst),
    .card_i      (card_i),
    .pass_i      (pass_i),
    .alarm_clr_i (alarm_clr_i),
    .state_o     (state_o),
    .lock_o      (lock_o)
  );

  // {alarm_clr, pass, card, expected state[1:0], expected lock}
  localparam int NVEC = 24;
  localparam logic [5:0] VEC [NVEC] = '{
    6'b000_00_1,  // R4 idle
    6'b011_00_1,  // R4 card and pass together
    6'b100_00_1,  // R4 alarm clear alone
    6'b101_00_1,  // R4 alarm clear blocks card
    6'b001_01_0,  // R2 card opens
    6'b001_01_0,  // R5 card held
    6'b011_01_0,  // R5 pass with card keeps open
    6'b000_01_0,  // R5 idle
    6'b100_01_0,  // R5 alarm clear ignored
    6'b110_00_1,  // R5 pass closes even with alarm clear
    6'b001_01_0,  // R2
    6'b010_00_1,  // R5 pass closes
    6'b010_10_0,  // R3 sneak
    6'b000_10_0,  // R6 hold
    6'b001_10_0,  // R6 card alone does not clear
    6'b011_10_0,  // R6
    6'b010_10_0,  // R6
    6'b100_00_1,  // R6 clear
    6'b110_00_1,  // R4 pass with clear stays locked
    6'b010_10_0,  // R3
    6'b111_00_1,  // R6 clear with all inputs
    6'b001_01_0,  // R2
    6'b111_01_0,  // R5 card present keeps open
    6'b110_00_1   // R5
  };

  task automatic chk(input string req, input logic [1:0] st, input logic lk,
                     input logic [1:0] exp_st, input logic exp_lk);
    applied++;
    if (st !== exp_st || lk !== exp_lk) begin
      bad++;
      $display("FAIL %s: state=%b lock=%b expected state=%b lock=%b",
               req, st, lk, exp_st, exp_lk);
    end
  endtask

  task automatic step(input logic a, input logic p, input logic c);
    alarm_clr_i = a;
    pass_i = p;
    card_i = c;
    @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R1", state_o, lock_o, 2'b00, 1'b1);  // reset state, R7 lock
    rst = 1'b0;

    for (int k = 0; k < NVEC; k++) begin
      step(VEC[k][5], VEC[k][4], VEC[k][3]);
      chk("R2-table", state_o, lock_o, VEC[k][2:1], VEC[k][0]);
      if (state_o == 2'b11) chk("R8", state_o, lock_o, 2'b00, 1'b1);
    end

    // R1: reset taken from open
    step(1'b0, 1'b0, 1'b1);
    chk("R2", state_o, lock_o, 2'b01, 1'b0);
    rst = 1'b1;
    step(1'b0, 1'b0, 1'b1);
    chk("R1", state_o, lock_o, 2'b00, 1'b1);
    rst = 1'b0;

    // R1: reset taken from alarm, with sneak still present
    step(1'b0, 1'b1, 1'b0);
    chk("R3", state_o, lock_o, 2'b10, 1'b0);
    rst = 1'b1;
    step(1'b0, 1'b1, 1'b0);
    chk("R1", state_o, lock_o, 2'b00, 1'b1);
    rst = 1'b0;

    // R6: long alarm with card waving, then clear
    step(1'b0, 1'b1, 1'b0);
    for (int k = 0; k < 8; k++) begin
      step(1'b0, k[0], 1'b1);
      chk("R6", state_o, lock_o, 2'b10, 1'b0);
    end
    step(1'b1, 1'b0, 1'b0);
    chk("R6", state_o, lock_o, 2'b00, 1'b1);
    step(1'b0, 1'b0, 1'b0);
    chk("R7", state_o, lock_o, 2'b00, 1'b1);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", applied, bad);
    $finish;
  end

  initial begin
    #100000;
    if (!done) begin
      bad++;
      $display("FAIL watchdog: run hung, actual=timeout expected=finish");
      $display("== %0d vectors applied, %0d miscompares ==", applied, bad);
      $finish;
    end
  end

endmodule